// File: doc/BRIEF.md
# Center-Aligned Up/Down Timer with Compare/Capture Channels

The block is a 16-bit timer that counts up from zero to a top value, turns around, counts back down to zero and repeats. The top value is held in channel 0's compare register. Channels 1 and 2 each drive one compare output pin. Each pin follows one of eight output-mode codes. Some modes depend on the counting direction. Others pair the channel's own compare value with the top value. Any channel can instead capture the current count on a rising edge of its capture input.

Four event flags record events: the counter arriving at zero, and one event per channel. The flags latch whether or not the event is masked, and they stay set until software clears them. A single interrupt line is raised while any flag with its mask bit set is pending. The counter advances once per clock while `en` is high.

The counter is a three-state machine: `ST_IDLE`, `ST_UP` and `ST_DOWN`. The state records the direction of the step that brought the count to its current value. Its transitions are:
- START: `ST_IDLE` to `ST_UP`, the first step from zero.
- CLIMB: `ST_UP` to `ST_UP`.
- PEAK: `ST_UP` to `ST_DOWN`, when the count is at or above the top.
- FALL: `ST_DOWN` to `ST_DOWN`.
- VALLEY: `ST_DOWN` to `ST_UP`, when leaving zero.
- COLLAPSE: any state to `ST_IDLE`, when the top is 0.

Software reaches the registers through a write port with a 3-bit address. Registers are written only; nothing is read back through this port.

| Address | Register |
|---|---|
| 0 | Top value (channel 0's value) |
| 1 | Channel 1 value |
| 2 | Channel 2 value |
| 3 | Overflow mask, in bit 0 |
| 4 | Channel 0 configuration |
| 5 | Channel 1 configuration |
| 6 | Channel 2 configuration |
| 7 | Flag clear, write-one-to-clear |

Each channel configuration register holds the output mode in bits 2:0, capture mode in bit 3 and the interrupt mask in bit 4.

Top module: `updn_cmp_timer`

## Requirements
- R1: After reset the following are all 0: `count`, `ch_value`, `cmp_out`, `flags` and `irq`.
- R2: With `en` high and a top value T > 0, the count follows 0,1,…,T,T-1,…,0,1,… and moves one step per enabled clock. It holds while `en` is low. A step is an "arrival" at the new value. An arrival is upward when it comes from the increasing side, and arriving at T counts as upward.
- R3: With a top value of 0, the counter sits at 0 and produces no arrival, so no event can fire.
- R4: Arriving at 0 from above sets the overflow flag, `flags[0]`.
- R5: A compare match is an arrival at a channel's own value while the channel is in compare mode. On a match, output mode 0 sets the pin, mode 1 clears it and mode 2 toggles it. The pin changes one clock after the count shows the matching value. Channel 1 drives `cmp_out[0]` and channel 2 drives `cmp_out[1]`.
- R6: Mode 3 sets the pin on an upward match and clears it on a downward match. Mode 4 clears it on an upward match and sets it on a downward match.
- R7: Mode 5 sets the pin on its own match and clears it on an arrival at the top value. Mode 6 clears the pin on its own match and sets it on an arrival at the top. When both happen together, the own-match action wins.
- R8: Mode 7 leaves the pin unchanged, but the channel flag is still set on a match.
- R9: Channel n's flag, `flags[n+1]`, is set on its compare match whatever its mask bit is. For channel 0, the match is an arrival at the top value.
- R10: A flag stays set until a write to address 7 with its bit at 1. If that clear lands in the same cycle as a new event for the flag, the flag stays set.
- R11: `irq` is high exactly when some flag is set together with its mask bit. The overflow mask is address 3 bit 0, and each channel mask is configuration bit 4.
- R12: In capture mode (configuration bit 3 = 1), a rising edge on `cap_in[n]` copies the count into channel n's value and sets its flag. A held-high input does not capture again. The channel makes no compare matches and its pin holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable, one step per clock while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see table above) |
| wr_data | input | 16 | Write data |
| cap_in | input | 3 | Capture input per channel |
| count | output | 16 | Current counter value |
| ch_value | output | 48 | Channel values, channel n in bits 16n+15:16n |
| cmp_out | output | 2 | Compare pins of channels 1 and 2 |
| flags | output | 4 | Event flags: bit 0 overflow, bit n+1 channel n |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties take for granted that `cap_in` is already synchronous to `clk`. They also assume that the top value is changed only while the counter is stopped or is set to zero. Under those conditions the count always moves by one, or falls back to zero on a COLLAPSE. The stimulus changes every input half a cycle away from the active edge. It writes the top and the channel settings only while `en` is low, and it raises capture inputs only when the channel is in capture mode.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    localparam int NUM_CH     = 3;
    localparam int NUM_FLAGS  = NUM_CH + 1;
    localparam int ADDR_W     = 3;
    localparam int CFG_MODE_W = 3;
    localparam int CFG_CAP_B  = 3;
    localparam int CFG_MASK_B = 4;
    localparam int CFG_W      = 5;

    localparam logic [ADDR_W-1:0] ADDR_VAL0     = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_OVF_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CFG0     = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_CLR      = 3'd7;

    // Counter state = direction of the step that reached the current count
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UP,
        ST_DOWN
    } ctr_state_t;

    typedef enum logic [CFG_MODE_W-1:0] {
        MODE_SET     = 3'd0,
        MODE_CLR     = 3'd1,
        MODE_TOGGLE  = 3'd2,
        MODE_UP_SET  = 3'd3,
        MODE_UP_CLR  = 3'd4,
        MODE_OWN_SET = 3'd5,
        MODE_OWN_CLR = 3'd6,
        MODE_HOLD    = 3'd7
    } out_mode_t;

endpackage

// File: rtl/updn_counter.sv
module updn_counter
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] count,
    output logic             stepped,
    output logic             going_up,
    output logic             ovf_evt,
    output logic             top_hit
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ctr_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_d;
    logic             step_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count   <= '0;
            stepped <= 1'b0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
            stepped <= step_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        count_d = count;
        step_d  = 1'b0;
        if (en) begin
            if (top == '0) begin
                // COLLAPSE
                state_d = ST_IDLE;
                count_d = '0;
            end else begin
                step_d = 1'b1;
                unique case (state_q)
                    ST_IDLE: begin          // START
                        state_d = ST_UP;
                        count_d = ONE;
                    end
                    ST_UP: begin
                        if (count >= top) begin   // PEAK
                            state_d = ST_DOWN;
                            count_d = count - ONE;
                        end else begin            // CLIMB
                            state_d = ST_UP;
                            count_d = count + ONE;
                        end
                    end
                    ST_DOWN: begin
                        if (count == '0) begin    // VALLEY
                            state_d = ST_UP;
                            count_d = ONE;
                        end else begin            // FALL
                            state_d = ST_DOWN;
                            count_d = count - ONE;
                        end
                    end
                    default: begin
                        state_d = ST_IDLE;
                        count_d = '0;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        going_up = (state_q == ST_UP);
        ovf_evt  = stepped && (state_q == ST_DOWN) && (count == '0);
        top_hit  = stepped && (count == top);
    end

endmodule

// File: rtl/updn_channel.sv
module updn_channel
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic             wr_cfg,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stepped,
    input  logic [CNT_W-1:0] count,
    input  logic             going_up,
    input  logic             top_hit,
    input  logic             cap_in,
    output logic [CNT_W-1:0] value,
    output logic             mask,
    output logic             event_o,
    output logic             pin
);

    out_mode_t mode_q;
    logic      cap_mode_q;
    logic      cap_prev_q;
    logic      own_hit;
    logic      cap_edge;
    logic      pin_d;

    always_comb begin
        own_hit  = stepped && !cap_mode_q && (count == value);
        cap_edge = cap_mode_q && cap_in && !cap_prev_q;
        event_o  = own_hit || cap_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value      <= '0;
            mode_q     <= MODE_SET;
            cap_mode_q <= 1'b0;
            mask       <= 1'b0;
            cap_prev_q <= 1'b0;
            pin        <= 1'b0;
        end else begin
            cap_prev_q <= cap_in;
            pin        <= pin_d;
            if (cap_edge) begin
                value <= count;
            end else if (wr_val) begin
                value <= wr_data;
            end
            if (wr_cfg) begin
                mode_q     <= out_mode_t'(wr_data[CFG_MODE_W-1:0]);
                cap_mode_q <= wr_data[CFG_CAP_B];
                mask       <= wr_data[CFG_MASK_B];
            end
        end
    end

    // Pin action per output mode
    always_comb begin
        pin_d = pin;
        if (!cap_mode_q) begin
            unique case (mode_q)
                MODE_SET:     if (own_hit) pin_d = 1'b1;
                MODE_CLR:     if (own_hit) pin_d = 1'b0;
                MODE_TOGGLE:  if (own_hit) pin_d = !pin;
                MODE_UP_SET:  if (own_hit) pin_d = going_up;
                MODE_UP_CLR:  if (own_hit) pin_d = !going_up;
                MODE_OWN_SET: begin
                    if (own_hit)      pin_d = 1'b1;
                    else if (top_hit) pin_d = 1'b0;
                end
                MODE_OWN_CLR: begin
                    if (own_hit)      pin_d = 1'b0;
                    else if (top_hit) pin_d = 1'b1;
                end
                MODE_HOLD:    pin_d = pin;
                default:      pin_d = pin;
            endcase
        end
    end

endmodule

// File: rtl/updn_flags.sv
module updn_flags
    import updn_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic [NUM_FLAGS-1:0] clr,
    input  logic [NUM_FLAGS-1:0] mask,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | evt;
        end
    end

    always_comb begin
        irq = |(flags & mask);
    end

endmodule

// File: rtl/updn_cmp_timer.sv
module updn_cmp_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       cap_in,
    output logic [CNT_W-1:0]        count,
    output logic [NUM_CH*CNT_W-1:0] ch_value,
    output logic [NUM_CH-2:0]       cmp_out,
    output logic [NUM_FLAGS-1:0]    flags,
    output logic                    irq
);

    logic [CNT_W-1:0]     val [NUM_CH];
    logic [NUM_CH-1:0]    ch_mask;
    logic [NUM_CH-1:0]    ch_evt;
    logic [NUM_CH-1:0]    ch_pin;
    logic [CNT_W-1:0]     top_val;
    logic                 stepped;
    logic                 going_up;
    logic                 ovf_evt;
    logic                 top_hit;
    logic                 ovf_mask_q;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] evt_vec;
    logic [NUM_FLAGS-1:0] mask_vec;
    logic                 ch0_pin_unused;

    assign top_val = val[0];

    updn_counter #(.CNT_W(CNT_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .top      (top_val),
        .count    (count),
        .stepped  (stepped),
        .going_up (going_up),
        .ovf_evt  (ovf_evt),
        .top_hit  (top_hit)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic wr_val_i;
        logic wr_cfg_i;
        assign wr_val_i = wr_en && (wr_addr == (ADDR_VAL0 + ADDR_W'(gi)));
        assign wr_cfg_i = wr_en && (wr_addr == (ADDR_CFG0 + ADDR_W'(gi)));

        updn_channel #(.CNT_W(CNT_W)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_val   (wr_val_i),
            .wr_cfg   (wr_cfg_i),
            .wr_data  (wr_data),
            .stepped  (stepped),
            .count    (count),
            .going_up (going_up),
            .top_hit  (top_hit),
            .cap_in   (cap_in[gi]),
            .value    (val[gi]),
            .mask     (ch_mask[gi]),
            .event_o  (ch_evt[gi]),
            .pin      (ch_pin[gi])
        );

        assign ch_value[gi*CNT_W +: CNT_W] = val[gi];
    end

    // Channel 0 sets the range and drives no pin
    assign ch0_pin_unused = ch_pin[0];
    assign cmp_out        = ch_pin[NUM_CH-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_mask_q <= 1'b0;
        end else if (wr_en && (wr_addr == ADDR_OVF_MASK)) begin
            ovf_mask_q <= wr_data[0];
        end
    end

    always_comb begin
        clr_vec  = (wr_en && (wr_addr == ADDR_CLR)) ? wr_data[NUM_FLAGS-1:0] : '0;
        evt_vec  = {ch_evt, ovf_evt};
        mask_vec = {ch_mask, ovf_mask_q};
    end

    updn_flags flg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_vec),
        .clr   (clr_vec),
        .mask  (mask_vec),
        .flags (flags),
        .irq   (irq)
    );

endmodule

// File: rtl/updn_cmp_timer_chk.sv
module updn_cmp_timer_chk
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic [CNT_W-1:0]     count,
    input logic [CNT_W-1:0]     top_val,
    input logic                 ovf_evt,
    input logic [NUM_FLAGS-1:0] evt_vec,
    input logic [NUM_FLAGS-1:0] clr_vec,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 irq
);

    // R2: one step at a time, or back to zero
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1) || (count == '0)));

    // R2: no movement while stopped
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R3: a zero top pins the counter at zero
    a_r3_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_val == '0) && (count == '0)) |=> (count == '0));

    // R4: a turnaround at zero is recorded
    a_r4_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flags[0]);

    // R10: flags only drop through an explicit clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags) & ~$past(clr_vec) & ~flags) == '0));

    // R10: a new event beats a clear in the same cycle
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_vec) & ~flags) == '0));

    // R11: the request needs a pending flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

endmodule

bind updn_cmp_timer updn_cmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .count   (count),
    .top_val (top_val),
    .ovf_evt (ovf_evt),
    .evt_vec (evt_vec),
    .clr_vec (clr_vec),
    .flags   (flags),
    .irq     (irq)
);

// File: tb/updn_cmp_timer_tb.sv
module updn_cmp_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [2:0]    cap_in = '0;
    logic [CW-1:0] count;
    logic [3*CW-1:0] ch_value;
    logic [1:0]    cmp_out;
    logic [3:0]    flags;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_cmp_timer #(.CNT_W(CW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cap_in   (cap_in),
        .count    (count),
        .ch_value (ch_value),
        .cmp_out  (cmp_out),
        .flags    (flags),
        .irq      (irq)
    );

    typedef struct packed {
        logic [15:0] top;
        logic [15:0] c1;
        logic [2:0]  m1;
        logic [15:0] c2;
        logic [2:0]  m2;
        logic [7:0]  steps;
        logic [15:0] exp_cnt;
        logic [1:0]  exp_out;
        logic [3:0]  exp_flags;
    } vec_t;

    localparam int NUM_VECS = 11;
    localparam vec_t VECS [NUM_VECS] = '{
        '{16'd4, 16'd2, 3'd0, 16'd1, 3'd1, 8'd2,  16'd2, 2'b01, 4'b1100},
        '{16'd4, 16'd2, 3'd3, 16'd3, 3'd4, 8'd6,  16'd2, 2'b10, 4'b1110},
        '{16'd4, 16'd2, 3'd3, 16'd3, 3'd4, 8'd5,  16'd3, 2'b11, 4'b1110},
        '{16'd3, 16'd3, 3'd2, 16'd0, 3'd2, 8'd10, 16'd2, 2'b10, 4'b1111},
        '{16'd5, 16'd2, 3'd5, 16'd4, 3'd6, 8'd4,  16'd4, 2'b01, 4'b1100},
        '{16'd5, 16'd2, 3'd5, 16'd4, 3'd6, 8'd5,  16'd5, 2'b10, 4'b1110},
        '{16'd5, 16'd2, 3'd5, 16'd4, 3'd6, 8'd8,  16'd2, 2'b01, 4'b1110},
        '{16'd3, 16'd5, 3'd0, 16'd2, 3'd7, 8'd10, 16'd2, 2'b00, 4'b1011},
        '{16'd4, 16'd4, 3'd5, 16'd4, 3'd6, 8'd4,  16'd4, 2'b01, 4'b1110},
        '{16'd1, 16'd0, 3'd2, 16'd1, 3'd0, 8'd5,  16'd1, 2'b10, 4'b1111},
        '{16'd0, 16'd0, 3'd0, 16'd0, 3'd0, 8'd5,  16'd0, 2'b00, 4'b0000}
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        cap_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_steps(input int n);
        @(negedge clk);
        en = 1'b1;
        repeat (n) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1 count", 48'(count), 48'd0);
        check("R1 ch_value", 48'(ch_value), 48'd0);
        check("R1 cmp_out", 48'(cmp_out), 48'd0);
        check("R1 flags", 48'(flags), 48'd0);
        check("R1 irq", 48'(irq), 48'd0);

        // Table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NUM_VECS; k++) begin
            do_reset();
            wr(3'd0, VECS[k].top);
            wr(3'd1, VECS[k].c1);
            wr(3'd2, VECS[k].c2);
            wr(3'd5, CW'(VECS[k].m1));
            wr(3'd6, CW'(VECS[k].m2));
            run_steps(int'(VECS[k].steps));
            check($sformatf("R2 R3 count vec%0d", k), 48'(count), 48'(VECS[k].exp_cnt));
            check($sformatf("R5 R6 R7 R8 pins vec%0d", k), 48'(cmp_out), 48'(VECS[k].exp_out));
            check($sformatf("R4 R9 flags vec%0d", k), 48'(flags), 48'(VECS[k].exp_flags));
        end

        // R2 hold while stopped
        do_reset();
        wr(3'd0, 16'd4);
        run_steps(3);
        check("R2 count after 3", 48'(count), 48'd3);
        repeat (5) @(negedge clk);
        check("R2 hold", 48'(count), 48'd3);

        // R11 masking, R9 flags latch while masked
        do_reset();
        wr(3'd0, 16'd2);
        wr(3'd1, 16'd1);
        run_steps(4);
        check("R9 flags unmasked-independent", 48'(flags), 48'hF);
        check("R11 irq all masked", 48'(irq), 48'd0);
        wr(3'd5, 16'h0010);
        check("R11 irq ch1 mask", 48'(irq), 48'd1);
        wr(3'd7, 16'h0004);
        check("R10 clear ch1", 48'(flags), 48'hB);
        check("R11 irq after clear", 48'(irq), 48'd0);
        wr(3'd3, 16'h0001);
        check("R11 irq ovf mask", 48'(irq), 48'd1);

        // R10 clear colliding with an event
        do_reset();
        wr(3'd0, 16'd2);
        wr(3'd1, 16'd1);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        while (count != 16'd1) @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 3'd7;
        wr_data = 16'h0004;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 event beats clear", 48'(flags[2]), 48'd1);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 clear without event", 48'(flags[2]), 48'd0);
        en = 1'b0;
        repeat (3) @(negedge clk);
        wr(3'd7, 16'h0004);
        repeat (4) @(negedge clk);
        check("R10 stays clear", 48'(flags[2]), 48'd0);

        // R12 capture
        do_reset();
        wr(3'd0, 16'd10);
        wr(3'd2, 16'd3);
        wr(3'd6, 16'h0008);
        run_steps(6);
        check("R12 no compare in capture", 48'(flags[3]), 48'd0);
        check("R12 pin holds", 48'(cmp_out[1]), 48'd0);
        cap_in[2] = 1'b1;
        @(negedge clk);
        check("R12 captured value", 48'(ch_value[2*CW +: CW]), 48'd6);
        check("R12 capture flag", 48'(flags[3]), 48'd1);
        wr(3'd7, 16'h0008);
        run_steps(2);
        check("R12 held high no recapture", 48'(ch_value[2*CW +: CW]), 48'd6);
        check("R12 no flag when held", 48'(flags[3]), 48'd0);
        cap_in[2] = 1'b0;
        @(negedge clk);
        cap_in[2] = 1'b1;
        @(negedge clk);
        check("R12 second capture", 48'(ch_value[2*CW +: CW]), 48'd8);
        check("R12 pin still holds", 48'(cmp_out[1]), 48'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule